// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one channel of an interval timer. A 16-bit down counter runs in plain binary or in four-digit decimal and drives a single output in one of six patterns. The patterns are: a level that rises at terminal count, a retriggerable one-shot, a periodic one-clock low pulse, a square wave, a one-clock strobe started by software, and a one-clock strobe started by the gate input. The counter takes one step on each clock edge where `cnt_en` is high. This lets a slower timing base be formed in the clock domain without a second clock.

Software reaches the channel through an 8-bit register port with two address bits. Address 3 takes a control byte. The address equal to the `CHAN_ID` parameter carries the count bytes: they are written to load the count and read to observe it. A control byte can also freeze a snapshot of the running count into a hold register. The snapshot is then read back byte by byte while the counter keeps running. Every access completes in the cycle it is presented. The port never stalls and applies no back-pressure, so there is no valid/ready pair on it. `gate` and `out` are plain level signals.

Top module: `pit_channel`

## Requirements
- R1: After reset `out` is 0, the channel is in mode 0 with binary counting and low-then-high byte access, and reading the count returns 0.
- R2: A write to address 3 is a control byte: bits 7:6 must equal `CHAN_ID`, or the byte is ignored entirely. Bits 5:4 set the access form (00 snapshot, 01 low byte, 10 high byte, 11 low then high). Bits 3:1 set the mode, with codes 6 and 7 acting as modes 2 and 3. Bit 0 selects decimal counting. A non-snapshot control byte stops counting and sets `out` low in mode 0 and high in every other mode.
- R3: Count bytes are written at address `CHAN_ID`. With low-then-high access the first write is the low byte and the second write completes the count; the byte order restarts at low after every control byte. With a single-byte access, one write completes the count and the other byte is 0. Writes to other data addresses have no effect.
- R4: Mode 0: completing a count drives `out` low. `out` rises at the N+1-th counting edge after the edge that took the final byte, and it stays high until a new count or control byte. Edges with `gate` low do not count.
- R5: Mode 1: `out` stays high until a `gate` rising edge arrives after a count exists. `out` is low from that edge for N counting edges, then high. A new rising edge during the low phase restarts the N-edge low phase.
- R6: Mode 2: `out` is high while counting. It is low for exactly one counting edge per period of N edges, and the count then reloads by itself. `gate` low holds `out` high and stops counting, and a `gate` rising edge restarts the period.
- R7: Mode 3: `out` is a square wave of period N edges. It is high for N/2 and low for N/2 edges when N is even, and high for (N+1)/2 and low for (N-1)/2 edges when N is odd.
- R8: Mode 4: after the final count byte, `out` stays high and pulses low for exactly one counting edge at the N+1-th counting edge. The count then keeps running without another pulse. `gate` low holds the count.
- R9: Mode 5: the count starts on a `gate` rising edge and not on the count write. `out` pulses low for exactly one counting edge at the N-th counting edge after the trigger edge.
- R10: In decimal mode each of the four 4-bit digits counts 9 down to 0 with borrow, so 0000 steps to 9999. A loaded count of 0 acts as the largest count (65536 binary, 10000 decimal), so the binary count 0 steps to FFFF. Counts loaded in decimal mode must have digits 0 to 9.
- R11: A snapshot control byte (bits 5:4 = 00) copies the live count into a hold register, unless a snapshot is already pending. Reads then return the held value, which does not move while the counter runs. The snapshot is released after the last byte of the current access form has been read.
- R12: A read of address `CHAN_ID` returns the low byte, the high byte, or alternately low then high, according to the access form. A read of any other address, or with `rd_en` low, returns 0.
- R13: While `cnt_en` is low the count does not change and no load or trigger takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address (3 = control byte) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle `rd_en` is high |
| cnt_en | input | 1 | Counting step enable |
| gate | input | 1 | Gate / trigger input |
| out | output | 1 | Timer output |

## Verification
On every cycle the assertions check four things. The one-clock width of the low pulse in modes 2, 4 and 5. That a mode 0 output, once high, stays high until new programming. That decimal digits stay in range while counting. That a held snapshot does not move while it waits to be read. Only the scenarios can show the exact edge on which each mode's output changes for a chosen count, the odd and even halves of the square wave, retriggering, and the effect of the gate. The scenarios also cover decimal and binary wrap-around and the byte order of reads and writes.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int DIGITS = CNT_W / 4;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  typedef enum logic [1:0] {
    ACC_SNAP = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_LOHI = 2'b11
  } acc_e;

  typedef enum logic [2:0] {
    M_TCINT   = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic mode_e decode_mode(input logic [2:0] f);
    return f[1] ? mode_e'({1'b0, f[1:0]}) : mode_e'(f);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v, input logic dec);
    logic [CNT_W-1:0] r;
    logic brw;
    if (!dec) return v - CNT_ONE;
    r   = v;
    brw = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (brw) begin
        if (v[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
        else begin
          r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
          brw = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic digits_ok(input logic [CNT_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/pit_regif.sv
module pit_regif
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic [CNT_W-1:0]  live_cnt,
  output mode_e             mode,
  output logic              bcd,
  output logic              cw_wr,
  output mode_e             cw_mode,
  output logic              cnt_wr,
  output logic [CNT_W-1:0]  cnt_val
);
  localparam logic [1:0] ID = 2'(CHAN_ID);

  acc_e              acc;
  logic              wr_hi, rd_hi, latched;
  logic [CNT_W-1:0]  hold;
  logic [BYTE_W-1:0] lo_byte;

  logic sel_cw, snap_cmd, data_wr, data_rd, rd_hi_sel, rd_last;
  logic [CNT_W-1:0] rd_src;

  assign sel_cw   = wr_en && (addr == 2'b11) && (wdata[7:6] == ID);
  assign snap_cmd = sel_cw && (acc_e'(wdata[5:4]) == ACC_SNAP);
  assign cw_wr    = sel_cw && !snap_cmd;
  assign cw_mode  = decode_mode(wdata[3:1]);
  assign data_wr  = wr_en && (addr == ID);
  assign data_rd  = rd_en && (addr == ID);

  always_comb begin
    cnt_wr  = 1'b0;
    cnt_val = '0;
    case (acc)
      ACC_LO:   begin cnt_wr = data_wr;          cnt_val = {{BYTE_W{1'b0}}, wdata}; end
      ACC_HI:   begin cnt_wr = data_wr;          cnt_val = {wdata, {BYTE_W{1'b0}}}; end
      ACC_LOHI: begin cnt_wr = data_wr && wr_hi; cnt_val = {wdata, lo_byte};        end
      default:  ;
    endcase
  end

  assign rd_src    = latched ? hold : live_cnt;
  assign rd_hi_sel = (acc == ACC_HI) || ((acc == ACC_LOHI) && rd_hi);
  assign rd_last   = (acc != ACC_LOHI) || rd_hi;
  assign rdata     = data_rd ? (rd_hi_sel ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0])
                             : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= ACC_LOHI;
      mode    <= M_TCINT;
      bcd     <= 1'b0;
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      latched <= 1'b0;
      hold    <= '0;
      lo_byte <= '0;
    end else if (cw_wr) begin
      acc     <= acc_e'(wdata[5:4]);
      mode    <= cw_mode;
      bcd     <= wdata[0];
      wr_hi   <= 1'b0;
      rd_hi   <= 1'b0;
      latched <= 1'b0;
    end else begin
      if (snap_cmd && !latched) begin
        hold    <= live_cnt;
        latched <= 1'b1;
      end
      if (data_wr && acc == ACC_LOHI) begin
        if (!wr_hi) lo_byte <= wdata;
        wr_hi <= ~wr_hi;
      end
      if (data_rd) begin
        if (acc == ACC_LOHI) rd_hi <= ~rd_hi;
        if (rd_last) latched <= 1'b0;
      end
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latched |=> (!latched || $stable(hold)));
endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             gate,
  input  mode_e            mode,
  input  logic             bcd,
  input  logic             cw_wr,
  input  mode_e            cw_mode,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  output logic [CNT_W-1:0] cnt,
  output logic             out
);
  logic [CNT_W-1:0] init_q, cnt_q, dec1, dec2, even_init;
  logic out_q, gate_q, running, have, load_pend, trig_pend, armed, extra;
  logic rise, trg;

  assign rise      = gate && !gate_q;
  assign trg       = (trig_pend || rise) && have;
  assign dec1      = cnt_dec(cnt_q, bcd);
  assign dec2      = cnt_dec(dec1, bcd);
  assign even_init = {init_q[CNT_W-1:1], 1'b0};
  assign cnt       = cnt_q;
  assign out       = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0; cnt_q <= '0; out_q <= 1'b0; gate_q <= 1'b0;
      running <= 1'b0; have <= 1'b0; load_pend <= 1'b0;
      trig_pend <= 1'b0; armed <= 1'b0; extra <= 1'b0;
    end else begin
      gate_q <= gate;
      if (cw_wr) begin
        out_q     <= (cw_mode != M_TCINT);
        running   <= 1'b0;
        have      <= 1'b0;
        load_pend <= 1'b0;
        trig_pend <= 1'b0;
        armed     <= 1'b0;
        extra     <= 1'b0;
      end else begin
        if (rise && have && (mode inside {M_ONESHOT, M_RATE, M_SQUARE, M_HWSTB}))
          trig_pend <= 1'b1;
        if (cnt_en) begin
          case (mode)
            M_TCINT, M_SWSTB: begin
              if (mode == M_SWSTB && !out_q) out_q <= 1'b1;
              if (load_pend) begin
                cnt_q <= init_q; load_pend <= 1'b0; running <= 1'b1; armed <= 1'b1;
              end else if (running && gate) begin
                cnt_q <= dec1;
                if (dec1 == '0 && armed) begin
                  armed <= 1'b0;
                  out_q <= (mode == M_TCINT);
                end
              end
            end
            M_ONESHOT, M_HWSTB: begin
              if (trg) begin
                cnt_q <= init_q; running <= 1'b1; armed <= 1'b1; trig_pend <= 1'b0;
                out_q <= (mode == M_HWSTB);
              end else begin
                if (mode == M_HWSTB && !out_q) out_q <= 1'b1;
                if (running) begin
                  cnt_q <= dec1;
                  if (dec1 == '0 && armed) begin
                    armed <= 1'b0;
                    out_q <= (mode == M_ONESHOT);
                  end
                end
              end
            end
            default: begin
              if (!gate) out_q <= 1'b1;
              else if (load_pend || trg) begin
                cnt_q <= (mode == M_RATE) ? init_q : even_init;
                out_q <= 1'b1; running <= 1'b1;
                load_pend <= 1'b0; trig_pend <= 1'b0; extra <= 1'b0;
              end else if (running) begin
                if (mode == M_RATE) begin
                  if (!out_q) begin
                    cnt_q <= init_q; out_q <= 1'b1;
                  end else begin
                    cnt_q <= dec1;
                    if (dec1 == CNT_ONE) out_q <= 1'b0;
                  end
                end else if (extra) begin
                  extra <= 1'b0; out_q <= 1'b0; cnt_q <= even_init;
                end else if (dec2 == '0) begin
                  if (out_q && init_q[0]) begin
                    extra <= 1'b1; cnt_q <= '0;
                  end else begin
                    out_q <= ~out_q; cnt_q <= even_init;
                  end
                end else cnt_q <= dec2;
              end
            end
          endcase
        end
        if (cnt_wr) begin
          init_q <= cnt_val;
          have   <= 1'b1;
          if (mode == M_TCINT) out_q <= 1'b0;
          if ((mode inside {M_TCINT, M_SWSTB}) ||
              ((mode inside {M_RATE, M_SQUARE}) && !running))
            load_pend <= 1'b1;
        end
      end
    end
  end

  // R6 R8 R9
  strobe_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode inside {M_RATE, M_SWSTB, M_HWSTB}) && !out_q && cnt_en && !cw_wr) |=> out_q);

  // R4
  tc_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_TCINT && out_q && !cw_wr && !cnt_wr) |=> out_q);

  // R10
  bcd_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bcd && running && digits_ok(init_q)) |-> digits_ok(cnt_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        cnt_en,
  input  logic        gate,
  output logic        out
);
  mode_e            mode, cw_mode;
  logic             bcd, cw_wr, cnt_wr;
  logic [CNT_W-1:0] cnt_val, live_cnt;

  pit_regif #(.CHAN_ID(CHAN_ID)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .mode(mode), .bcd(bcd),
    .cw_wr(cw_wr), .cw_mode(cw_mode), .cnt_wr(cnt_wr), .cnt_val(cnt_val)
  );

  pit_core u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .mode(mode), .bcd(bcd),
    .cw_wr(cw_wr), .cw_mode(cw_mode), .cnt_wr(cnt_wr), .cnt_val(cnt_val),
    .cnt(live_cnt), .out(out)
  );
endmodule

// File: tb/pit_channel_tb.sv
module pit_channel_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic       cnt_en = 1'b1, gate = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       out;

  always #(CLK_PERIOD/2) clk = ~clk;

  pit_channel u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cnt_en(cnt_en), .gate(gate), .out(out)
  );

  typedef struct { logic val; string tag; } exp_t;
  exp_t sb[$];
  int checks = 0, errors = 0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: one expected output level per cycle, sampled mid-cycle
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.tag, {15'd0, out}, {15'd0, e.val});
    end
  end

  task automatic push(logic v, int n, string tag);
    for (int i = 0; i < n; i++) sb.push_back('{v, tag});
  endtask
  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    step();
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1; step(); wr_en = 1'b0;
  endtask
  task automatic load16(logic [15:0] v);
    wr(2'd0, v[7:0]); wr(2'd0, v[15:8]);
  endtask
  task automatic rd(logic [7:0] exp, string tag);
    addr = 2'd0; rd_en = 1'b1; #1;
    check(tag, {8'd0, rdata}, {8'd0, exp});
    step(); rd_en = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check("R1 out after reset", {15'd0, out}, 16'd0);
    rd(8'h00, "R1 count after reset");

    // mode 0, count 4, gate low for three edges
    wr(2'd3, 8'h30); load16(16'h0004);
    push(1'b0, 8, "R4 low while counting"); push(1'b1, 2, "R4 high at terminal count");
    step(); step(); gate = 1'b0; step(); step(); step(); gate = 1'b1;
    drain();
    wr(2'd3, 8'h70);
    push(1'b1, 2, "R2 foreign select ignored");
    drain();
    wr(2'd1, 8'h05);
    push(1'b1, 2, "R3 other data address ignored");
    drain();

    // snapshot and live reads
    wr(2'd3, 8'h30); load16(16'h1234);
    step(); cnt_en = 1'b0; step(); step();
    rd(8'h34, "R13 frozen live low"); rd(8'h12, "R13 frozen live high");
    wr(2'd3, 8'h00);
    cnt_en = 1'b1; repeat (5) step(); cnt_en = 1'b0;
    rd(8'h34, "R11 held low"); rd(8'h12, "R11 held high");
    rd(8'h2F, "R11 live low after release"); rd(8'h12, "R12 live high");
    cnt_en = 1'b1;
    wr(2'd3, 8'h10); wr(2'd0, 8'h07); step(); cnt_en = 1'b0;
    rd(8'h07, "R3 R12 low-only read"); rd(8'h07, "R12 low-only read again");
    cnt_en = 1'b1;
    wr(2'd3, 8'h20); wr(2'd0, 8'h02); step(); cnt_en = 1'b0;
    rd(8'h02, "R3 R12 high-only read");
    cnt_en = 1'b1;

    // mode 1 one-shot with retrigger
    gate = 1'b0; wr(2'd3, 8'h32); load16(16'h0003); step();
    check("R5 idle high before trigger", {15'd0, out}, 16'd1);
    gate = 1'b1;
    push(1'b1, 1, "R5 before trigger"); push(1'b0, 3, "R5 low for N");
    push(1'b1, 2, "R5 high after count");
    drain();
    gate = 1'b0; step(); gate = 1'b1;
    push(1'b1, 1, "R5 before retrigger"); push(1'b0, 5, "R5 retriggered low");
    push(1'b1, 2, "R5 high after retrigger");
    step(); gate = 1'b0; step(); gate = 1'b1;
    drain();

    // mode 2, plain and aliased code
    wr(2'd3, 8'h34); load16(16'h0003);
    push(1'b1, 3, "R6 high"); push(1'b0, 1, "R6 pulse"); push(1'b1, 2, "R6 high");
    push(1'b0, 1, "R6 pulse"); push(1'b1, 1, "R6 high");
    drain();
    wr(2'd3, 8'h3C); load16(16'h0003);
    push(1'b1, 3, "R2 alias high"); push(1'b0, 1, "R2 alias pulse");
    push(1'b1, 2, "R2 alias high"); push(1'b0, 1, "R2 alias pulse");
    drain();

    // mode 3 odd and even
    wr(2'd3, 8'h36); load16(16'h0005);
    push(1'b1, 4, "R7 odd high"); push(1'b0, 2, "R7 odd low");
    push(1'b1, 3, "R7 odd high"); push(1'b0, 2, "R7 odd low");
    drain();
    wr(2'd3, 8'h36); load16(16'h0004);
    push(1'b1, 3, "R7 even high"); push(1'b0, 2, "R7 even low");
    push(1'b1, 2, "R7 even high"); push(1'b0, 2, "R7 even low");
    drain();

    // mode 4
    wr(2'd3, 8'h38); load16(16'h0003);
    push(1'b1, 4, "R8 high"); push(1'b0, 1, "R8 strobe"); push(1'b1, 6, "R8 single strobe");
    drain();

    // mode 5
    gate = 1'b0; wr(2'd3, 8'h3A); load16(16'h0002);
    push(1'b1, 4, "R9 no start without trigger");
    drain();
    gate = 1'b1;
    push(1'b1, 3, "R9 high after trigger"); push(1'b0, 1, "R9 strobe");
    push(1'b1, 2, "R9 high after strobe");
    drain();

    // decimal counting and wrap
    wr(2'd3, 8'h31); load16(16'h0010);
    push(1'b0, 11, "R10 decimal ten low"); push(1'b1, 2, "R10 decimal ten high");
    drain();
    wr(2'd3, 8'h31); load16(16'h0001);
    step(); step(); step(); cnt_en = 1'b0;
    rd(8'h99, "R10 decimal wrap low"); rd(8'h99, "R10 decimal wrap high");
    cnt_en = 1'b1;
    wr(2'd3, 8'h30); load16(16'h0000);
    step(); step(); cnt_en = 1'b0;
    rd(8'hFF, "R10 binary wrap low"); rd(8'hFF, "R10 binary wrap high");
    cnt_en = 1'b1;

    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule